// File: doc/BRIEF.md
# Multi-Context Configuration Loader

This block fills the configuration planes of a row-based reconfigurable array that keeps several contexts per region. The host issues a load command that names a region, a context plane and a configuration identifier. The block then reads that configuration from a local configuration cache, one wide beat per cycle, and writes each beat into the selected region and context plane. The host never waits for a load to finish. A load is accepted in one cycle unless the block has to refuse it with a stall.

The array reports which regions are executing. A load aimed at an executing region waits in a single holding slot until that region goes idle. Loads into other regions proceed at once, so one region can be rewritten while another keeps running. A load that arrives while the sequencer is still streaming also waits in the slot. The block keeps one valid bit for each (region, context) pair and answers every execute request with either a grant or a not-ready refusal, so stale or half-written configurations are never run.

Top module: `cfg_ctx_loader`

## Requirements
- R1: After reset, every valid bit is 0. The cache read enable, the plane write enable, the stall output, the grant and the refusal are all 0.
- R2: A load accepted while the sequencer is idle and the target region is not busy starts reading in the next cycle. It reads beats 0 to BEATS-1 in consecutive cycles, at cache address cfg_id*BEATS + beat.
- R3: Each beat is written to the plane one cycle after it is read. The write carries the cache data returned for that read, the target region, the context and the beat index.
- R4: The valid bit of the target pair is at index region*NUM_CTX + ctx of `ctx_valid`. It reads 0 from the cycle after a load starts. It reads 1 from the cycle after the last beat is written.
- R5: A load into a region whose `region_busy` bit is 1 does no cache read while that bit stays 1. It starts streaming in the cycle after the bit is seen low.
- R6: A load accepted while another load is streaming waits in the holding slot. Its first read comes two cycles after the last read of the earlier load.
- R7: `ld_stall` is 1 in any cycle where `ld_valid` is 1 and the holding slot is occupied. A stalled command is discarded and never streams.
- R8: A busy bit for a region other than the target has no effect on when a load starts or how it streams.
- R9: One cycle after `exec_req`, exactly one of `exec_grant` or `exec_refuse` is 1. It is the grant when the requested pair's valid bit is 1 and the refusal otherwise.
- R10: A load changes no valid bit except the bit of its own target pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load command present |
| ld_region | input | RW | Target region of the load |
| ld_ctx | input | CW | Target context plane of the load |
| ld_cfg_id | input | CFG_ID_W | Configuration identifier in the cache |
| ld_stall | output | 1 | Load refused because the holding slot is full |
| region_busy | input | NUM_REGIONS | Per-region executing flag from the array |
| cache_rd_en | output | 1 | Cache read strobe |
| cache_rd_addr | output | AW | Cache beat address |
| cache_rd_data | input | BEAT_W | Cache data, valid one cycle after the read |
| plane_wr_en | output | 1 | Plane write strobe |
| plane_wr_region | output | RW | Region being written |
| plane_wr_ctx | output | CW | Context plane being written |
| plane_wr_beat | output | BW | Beat index within the configuration |
| plane_wr_data | output | BEAT_W | Beat data written to the plane |
| exec_req | input | 1 | Execute request from the host |
| exec_region | input | RW | Region of the execute request |
| exec_ctx | input | CW | Context of the execute request |
| exec_grant | output | 1 | Pair is valid, execution allowed |
| exec_refuse | output | 1 | Pair not valid, execution refused |
| ctx_valid | output | NUM_REGIONS*NUM_CTX | Per-pair ready status |

## Verification
The main loading function is driven from a table of loads. Each entry varies the region, the context, the configuration identifier and the pattern of busy regions. This separates busy bits that must block a load from busy bits on other regions that must not. Entries that reload a pair already loaded show that the valid bit is cleared at the start of a load and not only set at its end. Each cache beat carries a different word, so a wrong address, a skipped beat or an off-by-one write cycle shows up as a data mismatch. Directed cases cover three orderings: a load held by a busy region with a second command refused behind it, two loads issued back to back, and execute requests to empty, loaded and reloaded pairs.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  // Cache line of a given beat of a given configuration.
  function automatic int cache_line(int cfg, int beat, int beats);
    return cfg * beats + beat;
  endfunction

  // Flat index of a (region, context) pair in the valid vector.
  function automatic int pair_slot(int region, int ctx, int nctx);
    return region * nctx + ctx;
  endfunction

endpackage

// File: rtl/cfl_pend_slot.sv
module cfl_pend_slot #(
  parameter int RW = 2,
  parameter int CW = 2,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_region,
  input  logic [CW-1:0] push_ctx,
  input  logic [IW-1:0] push_cfg,
  input  logic          pop,
  output logic          full,
  output logic [RW-1:0] hold_region,
  output logic [CW-1:0] hold_ctx,
  output logic [IW-1:0] hold_cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full        <= 1'b0;
      hold_region <= '0;
      hold_ctx    <= '0;
      hold_cfg    <= '0;
    end else if (push) begin
      full        <= 1'b1;
      hold_region <= push_region;
      hold_ctx    <= push_ctx;
      hold_cfg    <= push_cfg;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // R7: the top never overwrites an occupied slot
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: a held command stays put until it is launched
  a_r5_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && $stable(hold_region) && $stable(hold_cfg));

endmodule

// File: rtl/cfl_beat_seq.sv
module cfl_beat_seq
  import cfl_pkg::*;
#(
  parameter int RW    = 2,
  parameter int CW    = 2,
  parameter int IW    = 4,
  parameter int BEATS = 8,
  parameter int BW    = 3,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] start_region,
  input  logic [CW-1:0] start_ctx,
  input  logic [IW-1:0] start_cfg,
  output logic          idle,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [RW-1:0] wr_region,
  output logic [CW-1:0] wr_ctx,
  output logic [BW-1:0] wr_beat,
  output logic          done
);

  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          active;
  logic [BW-1:0] beat_q;
  logic [RW-1:0] reg_q;
  logic [CW-1:0] ctx_q;
  logic [IW-1:0] cfg_q;

  // read stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat_q <= '0;
      reg_q  <= '0;
      ctx_q  <= '0;
      cfg_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat_q <= '0;
      reg_q  <= start_region;
      ctx_q  <= start_ctx;
      cfg_q  <= start_cfg;
    end else if (active) begin
      if (beat_q == LAST) active <= 1'b0;
      else                beat_q <= beat_q + BW'(1);
    end
  end

  assign idle    = !active;
  assign rd_en   = active;
  assign rd_addr = AW'(cache_line(int'(cfg_q), int'(beat_q), BEATS));

  // write stage, one cycle behind the read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_region <= '0;
      wr_ctx    <= '0;
      wr_beat   <= '0;
    end else begin
      wr_en     <= active;
      wr_region <= reg_q;
      wr_ctx    <= ctx_q;
      wr_beat   <= beat_q;
    end
  end

  assign done = wr_en && (wr_beat == LAST);

  // R2: a new stream only begins on an idle sequencer
  a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

  // R2: beats advance by one per cycle while streaming
  a_r2_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start && beat_q != LAST |=> active && beat_q == $past(beat_q) + BW'(1));

  // R3: every read is followed by the write of the same beat
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en && wr_beat == $past(beat_q) && wr_region == $past(reg_q));

endmodule

// File: rtl/cfl_valid_table.sv
module cfl_valid_table #(
  parameter int NPAIR = 16,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [PW-1:0]    clr_idx,
  input  logic             set_en,
  input  logic [PW-1:0]    set_idx,
  input  logic             exec_req,
  input  logic [PW-1:0]    exec_idx,
  output logic [NPAIR-1:0] valid,
  output logic             grant,
  output logic             refuse
);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n)                                  valid[g] <= 1'b0;
      else if (clr_en && clr_idx == PW'(g))        valid[g] <= 1'b0;
      else if (set_en && set_idx == PW'(g))        valid[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      refuse <= 1'b0;
    end else begin
      grant  <= exec_req &&  valid[exec_idx];
      refuse <= exec_req && !valid[exec_idx];
    end
  end

  // R9: never both answers at once
  a_r9_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && refuse));

  // R9: a request to a pair without valid data is refused
  a_r9_refuse_stale: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req && !valid[exec_idx] |=> refuse);

endmodule

// File: rtl/cfg_ctx_loader.sv
module cfg_ctx_loader
  import cfl_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_CTX     = 4,
  parameter int BEAT_W      = 192,
  parameter int BEATS       = 8,
  parameter int CFG_ID_W    = 4,
  localparam int RW    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int CW    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int AW    = CFG_ID_W + BW,
  localparam int NPAIR = NUM_REGIONS * NUM_CTX,
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [RW-1:0]          ld_region,
  input  logic [CW-1:0]          ld_ctx,
  input  logic [CFG_ID_W-1:0]    ld_cfg_id,
  output logic                   ld_stall,
  input  logic [NUM_REGIONS-1:0] region_busy,
  output logic                   cache_rd_en,
  output logic [AW-1:0]          cache_rd_addr,
  input  logic [BEAT_W-1:0]      cache_rd_data,
  output logic                   plane_wr_en,
  output logic [RW-1:0]          plane_wr_region,
  output logic [CW-1:0]          plane_wr_ctx,
  output logic [BW-1:0]          plane_wr_beat,
  output logic [BEAT_W-1:0]      plane_wr_data,
  input  logic                   exec_req,
  input  logic [RW-1:0]          exec_region,
  input  logic [CW-1:0]          exec_ctx,
  output logic                   exec_grant,
  output logic                   exec_refuse,
  output logic [NPAIR-1:0]       ctx_valid
);

  // named internal events
  logic                pend_full;
  logic [RW-1:0]       pend_region;
  logic [CW-1:0]       pend_ctx;
  logic [CFG_ID_W-1:0] pend_cfg;
  logic                seq_idle;
  logic                accept, direct, push, launch, start;
  logic [RW-1:0]       start_region;
  logic [CW-1:0]       start_ctx;
  logic [CFG_ID_W-1:0] start_cfg;
  logic                load_done;
  logic [PW-1:0]       start_idx, done_idx, exec_idx;

  assign accept   = ld_valid && !pend_full;
  assign ld_stall = ld_valid && pend_full;
  assign direct   = accept && seq_idle && !region_busy[ld_region];
  assign push     = accept && !direct;
  assign launch   = pend_full && seq_idle && !region_busy[pend_region];
  assign start    = direct || launch;

  assign start_region = launch ? pend_region : ld_region;
  assign start_ctx    = launch ? pend_ctx    : ld_ctx;
  assign start_cfg    = launch ? pend_cfg    : ld_cfg_id;

  assign start_idx = PW'(pair_slot(int'(start_region), int'(start_ctx), NUM_CTX));
  assign done_idx  = PW'(pair_slot(int'(plane_wr_region), int'(plane_wr_ctx), NUM_CTX));
  assign exec_idx  = PW'(pair_slot(int'(exec_region), int'(exec_ctx), NUM_CTX));

  cfl_pend_slot #(.RW(RW), .CW(CW), .IW(CFG_ID_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .push_region (ld_region),
    .push_ctx    (ld_ctx),
    .push_cfg    (ld_cfg_id),
    .pop         (launch),
    .full        (pend_full),
    .hold_region (pend_region),
    .hold_ctx    (pend_ctx),
    .hold_cfg    (pend_cfg)
  );

  cfl_beat_seq #(.RW(RW), .CW(CW), .IW(CFG_ID_W), .BEATS(BEATS), .BW(BW), .AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_region (start_region),
    .start_ctx    (start_ctx),
    .start_cfg    (start_cfg),
    .idle         (seq_idle),
    .rd_en        (cache_rd_en),
    .rd_addr      (cache_rd_addr),
    .wr_en        (plane_wr_en),
    .wr_region    (plane_wr_region),
    .wr_ctx       (plane_wr_ctx),
    .wr_beat      (plane_wr_beat),
    .done         (load_done)
  );

  assign plane_wr_data = cache_rd_data;

  cfl_valid_table #(.NPAIR(NPAIR), .PW(PW)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (start),
    .clr_idx  (start_idx),
    .set_en   (load_done),
    .set_idx  (done_idx),
    .exec_req (exec_req),
    .exec_idx (exec_idx),
    .valid    (ctx_valid),
    .grant    (exec_grant),
    .refuse   (exec_refuse)
  );

  // R5: a stream never starts into an executing region
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !region_busy[start_region]);

  // R4: the target pair reads invalid once its load has begun
  a_r4_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ctx_valid[$past(start_idx)]);

  // R4: the pair reads valid after its last beat is written
  a_r4_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    load_done && !(start && start_idx == done_idx) |=> ctx_valid[$past(done_idx)]);

  // R7: a stalled command neither queues nor streams
  a_r7_stall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> !push && !direct);

endmodule

// File: tb/cfg_ctx_loader_test.sv
`timescale 1ns/1ps
module cfg_ctx_loader_test;

  localparam int NR = 4, NC = 4, BW192 = 192, NB = 8, IW = 4;
  localparam int AW = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ld_valid = 1'b0;
  logic [1:0]     ld_region = '0, ld_ctx = '0;
  logic [IW-1:0]  ld_cfg_id = '0;
  logic           ld_stall;
  logic [NR-1:0]  region_busy = '0;
  logic           cache_rd_en;
  logic [AW-1:0]  cache_rd_addr;
  logic [BW192-1:0] cache_rd_data = '0;
  logic           plane_wr_en;
  logic [1:0]     plane_wr_region, plane_wr_ctx;
  logic [2:0]     plane_wr_beat;
  logic [BW192-1:0] plane_wr_data;
  logic           exec_req = 1'b0;
  logic [1:0]     exec_region = '0, exec_ctx = '0;
  logic           exec_grant, exec_refuse;
  logic [NR*NC-1:0] ctx_valid;

  int checks = 0, failures = 0;
  logic [15:0] exp_valid = '0;

  always #2 clk = ~clk;

  cfg_ctx_loader uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_region(ld_region),
    .ld_ctx(ld_ctx), .ld_cfg_id(ld_cfg_id), .ld_stall(ld_stall),
    .region_busy(region_busy), .cache_rd_en(cache_rd_en),
    .cache_rd_addr(cache_rd_addr), .cache_rd_data(cache_rd_data),
    .plane_wr_en(plane_wr_en), .plane_wr_region(plane_wr_region),
    .plane_wr_ctx(plane_wr_ctx), .plane_wr_beat(plane_wr_beat),
    .plane_wr_data(plane_wr_data), .exec_req(exec_req),
    .exec_region(exec_region), .exec_ctx(exec_ctx),
    .exec_grant(exec_grant), .exec_refuse(exec_refuse), .ctx_valid(ctx_valid)
  );

  // cache model: distinct word per lane and per line, one cycle latency
  function automatic logic [BW192-1:0] line_word(int line);
    logic [BW192-1:0] w;
    for (int k = 0; k < 6; k++) w[k*32 +: 32] = 32'h5A000000 + 32'(line * 16 + k);
    return w;
  endfunction

  always @(posedge clk) cache_rd_data <= line_word(int'(cache_rd_addr));

  task automatic chk(input bit ok, input string req, input logic [BW192-1:0] act,
                     input logic [BW192-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot(int r, int c);
    return r * NC + c;
  endfunction

  // called at the negedge before the edge on which the stream starts
  task automatic track(input int r, input int c, input int cfg);
    logic [15:0] bitm;
    bitm = 16'(1) << slot(r, c);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      ld_valid = 1'b0;
      chk(cache_rd_en && cache_rd_addr == AW'(cfg * NB + b), "R2 read",
          {cache_rd_en, cache_rd_addr}, {1'b1, AW'(cfg * NB + b)});
      if (b == 0) begin
        chk(ctx_valid == (exp_valid & ~bitm), "R4 clear/R10", ctx_valid, exp_valid & ~bitm);
        exp_valid = exp_valid & ~bitm;
      end else begin
        chk(plane_wr_en && plane_wr_beat == 3'(b - 1) && plane_wr_region == 2'(r) &&
            plane_wr_ctx == 2'(c) && plane_wr_data == line_word(cfg * NB + b - 1),
            "R3 write", plane_wr_data, line_word(cfg * NB + b - 1));
      end
    end
    @(negedge clk);
    chk(plane_wr_en && plane_wr_beat == 3'(NB - 1) && !cache_rd_en &&
        plane_wr_data == line_word(cfg * NB + NB - 1),
        "R3 last write", plane_wr_data, line_word(cfg * NB + NB - 1));
    @(negedge clk);
    exp_valid = exp_valid | bitm;
    chk(ctx_valid == exp_valid && !plane_wr_en, "R4 set/R10", ctx_valid, exp_valid);
  endtask

  task automatic exec_chk(input int r, input int c, input bit want_grant);
    exec_region = 2'(r); exec_ctx = 2'(c); exec_req = 1'b1;
    @(negedge clk);
    exec_req = 1'b0;
    chk(exec_grant == want_grant && exec_refuse == !want_grant, "R9 exec answer",
        {exec_grant, exec_refuse}, {want_grant, !want_grant});
  endtask

  task automatic drive_load(input int r, input int c, input int cfg);
    ld_valid = 1'b1; ld_region = 2'(r); ld_ctx = 2'(c); ld_cfg_id = IW'(cfg);
  endtask

  // {region[11:10], ctx[9:8], cfg[7:4], busy mask[3:0]}; target region never busy
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 4'd3,  4'b0000},
    {2'd1, 2'd2, 4'd15, 4'b0001},
    {2'd3, 2'd3, 4'd0,  4'b0110},
    {2'd2, 2'd1, 4'd9,  4'b1011},
    {2'd0, 2'd0, 4'd5,  4'b1110},
    {2'd1, 2'd2, 4'd7,  4'b0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctx_valid == '0 && !cache_rd_en && !plane_wr_en && !ld_stall &&
        !exec_grant && !exec_refuse, "R1 reset", ctx_valid, '0);
    exec_chk(2, 3, 1'b0);

    // table walk: R2 R3 R4 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      region_busy = VEC[i][3:0];
      drive_load(int'(VEC[i][11:10]), int'(VEC[i][9:8]), int'(VEC[i][7:4]));
      track(int'(VEC[i][11:10]), int'(VEC[i][9:8]), int'(VEC[i][7:4]));
      region_busy = '0;
      exec_chk(int'(VEC[i][11:10]), int'(VEC[i][9:8]), 1'b1);
    end

    // R5 held by busy region, R7 second command stalled and discarded
    region_busy = 4'b0010;
    drive_load(1, 3, 6);
    @(negedge clk);
    ld_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!cache_rd_en, "R5 held while busy", cache_rd_en, 0);
    end
    drive_load(2, 0, 1);
    #1;
    chk(ld_stall, "R7 stall", ld_stall, 1);
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    chk(!ld_stall, "R7 stall drops", ld_stall, 0);
    region_busy = '0;
    track(1, 3, 6);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(!cache_rd_en && ctx_valid == exp_valid, "R7 discarded", ctx_valid, exp_valid);
    end

    // R6 back-to-back loads
    drive_load(0, 1, 2);
    @(negedge clk);
    drive_load(3, 0, 4);
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (7) @(negedge clk);
    exp_valid = exp_valid | (16'(1) << slot(0, 1));
    track(3, 0, 4);
    exec_chk(0, 1, 1'b1);
    exec_chk(2, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule